// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of peripheral interrupt request lines and a processor core. Each request line has its own enable flag, a single pending flag, and a programmable urgency level. On every cycle the controller looks for the most urgent enabled pending source. It offers that source to the core only when no handler is running, or when the newcomer is strictly more urgent than the handler now running. The offer carries the byte address of the handler's entry in a table of handler addresses. The first sixteen entries of that table are kept for the stack pointer and the system exceptions, so peripheral n uses entry 16 + n.

The core accepts an offer with a one-cycle take strobe and ends a handler with a one-cycle return strobe. Inside, a hardware stack holds the urgency of every handler in progress. A preempted handler therefore comes back into force when the more urgent one returns. The offer is computed again against the state left by that return. Software sets enables and urgency levels, clears pending flags, and reads the pending map and the nesting depth through a small register port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, nothing is offered (`irq_valid` low), and the enable mask, the pending map and the nesting depth all read as zero.
- R2: A rising edge on `irq_in[n]` sets pending bit n. A source whose enable bit is clear is never offered, but its pending bit stays set and can be read back at register address 2 (bit n is source n).
- R3: Among enabled pending sources, the one with the numerically smallest priority value is offered. On equal values, the lowest source index wins.
- R4: `irq_vector` equals VEC_BASE + 4·(16 + n) for offered source n. VEC_BASE is 0 by default, so source 0 gives 64 and source 4 gives 80.
- R5: While a handler runs, a source is offered only if its priority value is strictly smaller than that of the running handler. Each take increases the nesting depth by one, and the depth can be read at register address 4.
- R6: A source of equal or lower urgency waits until the running handler returns. It is offered in the cycle right after the return strobe is sampled.
- R7: Any number of rising edges on a source while it waits produce exactly one service.
- R8: A take clears the pending bit of the taken source. If a new rising edge of that same source falls in the take cycle, the bit stays set and the source is taken again after its handler returns.
- R9: Writing ones to register address 1 clears the matching pending bits.
- R10: Register address 0 holds the enable mask (write the full mask, read it back). A write to address 3 sets the priority of the source given in wdata[15:8] to wdata[PRIO_W-1:0]. Read data appears on the clock edge that samples `cfg_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Peripheral request lines; a rising edge requests service |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Registered read data |
| irq_valid | output | 1 | A source is offered to the core |
| irq_vector | output | VEC_W | Byte address of the offered source's table entry |
| irq_ack | input | 1 | Core takes the current offer |
| irq_done | input | 1 | Core returns from the innermost handler |

## Verification
Two events are made to share one clock edge: the core's take of a source, and a fresh rising edge on that same source's request line. The bench raises the line on the same negative edge on which it asserts the take. It then reads the pending map and finds the bit still set, sees no offer while the equal-priority handler runs, and expects a second service of the same vector after the return. A second pairing, a return and the re-evaluation of a waiting source, is judged by sampling `irq_valid` half a cycle after the return strobe.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int unsigned REG_AW        = 3;
  localparam int unsigned SYS_ENTRIES   = 16;
  localparam int unsigned ENTRY_BYTES   = 4;
  localparam int unsigned PRIO_IDX_LSB  = 8;
  localparam int unsigned PRIO_IDX_W    = 8;

  typedef enum logic [REG_AW-1:0] {
    REG_ENABLE   = 3'd0,
    REG_PEND_CLR = 3'd1,
    REG_PEND     = 3'd2,
    REG_PRIO     = 3'd3,
    REG_DEPTH    = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/ipc_pend_bank.sv
// Edge detection and the single pending flag of every source.
module ipc_pend_bank #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned SRC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] clr_mask,
  input  logic               take_en,
  input  logic [SRC_W-1:0]   take_idx,
  output logic [NUM_SRC-1:0] rise,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] pend_nxt
);
  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] take_mask;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_take
    assign take_mask[i] = take_en && (take_idx == SRC_W'(i));
  end

  always_comb begin
    rise     = irq_in & ~req_q;
    // a new edge in the same cycle as a take or clear is a new occurrence
    pend_nxt = (pend_q & ~clr_mask & ~take_mask) | rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= irq_in;
      pend_q <= pend_nxt;
    end
  end
endmodule

// File: rtl/ipc_winner_sel.sv
// Picks the candidate with the smallest priority value, lowest index on ties.
module ipc_winner_sel #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned SRC_W   = 3,
  parameter int unsigned PRIO_W  = 3
) (
  input  logic [NUM_SRC-1:0]        cand,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  output logic                      found,
  output logic [SRC_W-1:0]          win_idx,
  output logic [PRIO_W-1:0]         win_prio
);
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!found || (prio[i*PRIO_W +: PRIO_W] < win_prio))) begin
        found    = 1'b1;
        win_idx  = SRC_W'(i);
        win_prio = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/ipc_active_stack.sv
// Stack of priorities of the handlers in progress.
module ipc_active_stack #(
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned LEVELS  = 8,
  parameter int unsigned DEPTH_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [PRIO_W-1:0]  push_prio,
  input  logic               pop,
  output logic [DEPTH_W-1:0] depth_q,
  output logic [PRIO_W-1:0]  top_q,
  output logic [DEPTH_W-1:0] depth_nxt,
  output logic [PRIO_W-1:0]  top_nxt
);
  localparam int unsigned IDX_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  logic [PRIO_W-1:0] stk [LEVELS];
  logic              full;
  logic              do_push;

  assign full    = (depth_q == DEPTH_W'(LEVELS));
  assign do_push = push && !full;

  always_comb begin
    if (do_push)
      depth_nxt = depth_q + 1'b1;
    else if (pop && (depth_q != '0))
      depth_nxt = depth_q - 1'b1;
    else
      depth_nxt = depth_q;

    if (do_push)
      top_nxt = push_prio;
    else if (depth_nxt == '0)
      top_nxt = '0;
    else
      top_nxt = stk[IDX_W'(depth_nxt - 1'b1)];

    if (depth_q == '0)
      top_q = '0;
    else
      top_q = stk[IDX_W'(depth_q - 1'b1)];
  end

  always_ff @(posedge clk) begin
    if (do_push)
      stk[IDX_W'(depth_q)] <= push_prio;
  end

  always_ff @(posedge clk) begin
    if (rst) depth_q <= '0;
    else     depth_q <= depth_nxt;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import ipc_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned PRIO_W   = 3,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned VEC_W    = 32,
  parameter logic [VEC_W-1:0] VEC_BASE = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   irq_in,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [REG_AW-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  output logic                 irq_valid,
  output logic [VEC_W-1:0]     irq_vector,
  input  logic                 irq_ack,
  input  logic                 irq_done
);
  localparam int unsigned SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int unsigned LEVELS  = 1 << PRIO_W;
  localparam int unsigned DEPTH_W = $clog2(LEVELS + 1);

  logic [NUM_SRC-1:0]        en_q, en_nxt;
  logic [NUM_SRC*PRIO_W-1:0] prio_q, prio_nxt;
  logic [NUM_SRC-1:0]        clr_mask, prio_hit;
  logic                      en_wr, clr_wr, prio_wr;

  logic [NUM_SRC-1:0]        rise, pend_q, pend_nxt;
  logic                      win_found;
  logic [SRC_W-1:0]          win_idx;
  logic [PRIO_W-1:0]         win_prio;

  logic [DEPTH_W-1:0]        depth_q, depth_nxt;
  logic [PRIO_W-1:0]         top_q, top_nxt;

  logic [SRC_W-1:0]          offer_src_q;
  logic [PRIO_W-1:0]         offer_prio_q;
  logic                      push, pop, preempt_ok;

  wire unused_wdata = ^cfg_wdata;

  // register port decode
  assign en_wr   = cfg_wr && (cfg_addr == REG_ENABLE);
  assign clr_wr  = cfg_wr && (cfg_addr == REG_PEND_CLR);
  assign prio_wr = cfg_wr && (cfg_addr == REG_PRIO);

  assign en_nxt   = en_wr  ? cfg_wdata[NUM_SRC-1:0] : en_q;
  assign clr_mask = clr_wr ? cfg_wdata[NUM_SRC-1:0] : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    assign prio_hit[i] = prio_wr &&
      (cfg_wdata[PRIO_IDX_LSB +: PRIO_IDX_W] == PRIO_IDX_W'(i));
    assign prio_nxt[i*PRIO_W +: PRIO_W] =
      prio_hit[i] ? cfg_wdata[PRIO_W-1:0] : prio_q[i*PRIO_W +: PRIO_W];
  end

  // core handshake: a take wins over a return in the same cycle
  assign push = irq_ack && irq_valid;
  assign pop  = irq_done && !push;

  ipc_pend_bank #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .irq_in   (irq_in),
    .clr_mask (clr_mask),
    .take_en  (push),
    .take_idx (offer_src_q),
    .rise     (rise),
    .pend_q   (pend_q),
    .pend_nxt (pend_nxt)
  );

  ipc_active_stack #(.PRIO_W(PRIO_W), .LEVELS(LEVELS), .DEPTH_W(DEPTH_W)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_prio (offer_prio_q),
    .pop       (pop),
    .depth_q   (depth_q),
    .top_q     (top_q),
    .depth_nxt (depth_nxt),
    .top_nxt   (top_nxt)
  );

  // selection runs on the state that the current edge will leave behind
  ipc_winner_sel #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_sel (
    .cand     (pend_nxt & en_nxt),
    .prio     (prio_nxt),
    .found    (win_found),
    .win_idx  (win_idx),
    .win_prio (win_prio)
  );

  assign preempt_ok = (depth_nxt == '0) || (win_prio < top_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q         <= '0;
      prio_q       <= '0;
      irq_valid    <= 1'b0;
      offer_src_q  <= '0;
      offer_prio_q <= '0;
      irq_vector   <= '0;
      cfg_rdata    <= '0;
    end else begin
      en_q         <= en_nxt;
      prio_q       <= prio_nxt;
      irq_valid    <= win_found && preempt_ok;
      offer_src_q  <= win_idx;
      offer_prio_q <= win_prio;
      irq_vector   <= VEC_BASE + VEC_W'(ENTRY_BYTES * (SYS_ENTRIES + int'(win_idx)));
      if (cfg_rd) begin
        case (reg_sel_e'(cfg_addr))
          REG_ENABLE: cfg_rdata <= DATA_W'(en_q);
          REG_PEND:   cfg_rdata <= DATA_W'(pend_q);
          REG_DEPTH:  cfg_rdata <= DATA_W'(depth_q);
          default:    cfg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned SRC_W   = 3,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned LEVELS  = 8,
  parameter int unsigned DEPTH_W = 4,
  parameter int unsigned VEC_W   = 32,
  parameter logic [VEC_W-1:0] VEC_BASE = '0
) (
  input logic               clk,
  input logic               rst,
  input logic               irq_valid,
  input logic               irq_ack,
  input logic [VEC_W-1:0]   irq_vector,
  input logic [SRC_W-1:0]   offer_src,
  input logic [PRIO_W-1:0]  offer_prio,
  input logic [DEPTH_W-1:0] depth,
  input logic [PRIO_W-1:0]  top_prio,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] en,
  input logic [NUM_SRC-1:0] rise
);
  assert_offer_enabled_R2: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (en[offer_src] && pend[offer_src]));

  assert_vector_addr_R4: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_vector == VEC_BASE + VEC_W'(64 + 4 * int'(offer_src))));

  assert_strict_preempt_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && (depth != '0)) |-> (offer_prio < top_prio));

  assert_take_nests_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_ack) |=> (depth == DEPTH_W'($past(depth) + 1'b1)));

  assert_depth_bound_R5: assert property (@(posedge clk) disable iff (rst)
    depth <= DEPTH_W'(LEVELS));

  assert_take_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_ack && !rise[offer_src]) |=> !pend[$past(offer_src)]);
endmodule

bind prio_irq_ctrl ipc_checker #(
  .NUM_SRC (NUM_SRC),
  .SRC_W   (SRC_W),
  .PRIO_W  (PRIO_W),
  .LEVELS  (LEVELS),
  .DEPTH_W (DEPTH_W),
  .VEC_W   (VEC_W),
  .VEC_BASE(VEC_BASE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_valid  (irq_valid),
  .irq_ack    (irq_ack),
  .irq_vector (irq_vector),
  .offer_src  (offer_src_q),
  .offer_prio (offer_prio_q),
  .depth      (depth_q),
  .top_prio   (top_q),
  .pend       (pend_q),
  .en         (en_q),
  .rise       (rise)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  localparam int N = 8;
  localparam real HALF = 4.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq_valid;
  logic [31:0] irq_vector;
  logic        irq_ack = 1'b0;
  logic        irq_done = 1'b0;

  int errors = 0;
  int checks = 0;
  bit auto_take = 1'b0;
  bit force_take = 1'b0;
  logic [31:0] exp_q[$];

  always #(HALF) clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_valid(irq_valid), .irq_vector(irq_vector),
    .irq_ack(irq_ack), .irq_done(irq_done)
  );

  function automatic logic [31:0] vec_of(input int src);
    return 32'(4 * (16 + src));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: takes offers and compares them with the scoreboard
  always @(negedge clk) begin
    #1;
    if (irq_valid && (auto_take || force_take)) begin
      irq_ack = 1'b1;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected take", irq_vector, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(irq_vector == e, "R4 taken vector", irq_vector, e);
      end
    end else begin
      irq_ack = 1'b0;
    end
  end

  task automatic expect_take(input int src);
    exp_q.push_back(vec_of(src));
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk);
    irq_in = irq_in | m;
    @(negedge clk);
    irq_in = irq_in & ~m;
  endtask

  task automatic ret();
    @(negedge clk);
    irq_done = 1'b1;
    @(negedge clk);
    irq_done = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_prio(input int src, input int p);
    cfg_write(3'd3, 32'((src << 8) | p));
  endtask

  initial begin
    #(HALF * 2 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    check(irq_valid == 1'b0, "R1 valid after reset", 32'(irq_valid), 0);
    cfg_read(3'd0, rd); check(rd == 0, "R1 enable after reset", rd, 0);
    cfg_read(3'd2, rd); check(rd == 0, "R1 pending after reset", rd, 0);
    cfg_read(3'd4, rd); check(rd == 0, "R1 depth after reset", rd, 0);

    // R10: configuration
    set_prio(0, 5); set_prio(1, 2); set_prio(2, 2); set_prio(3, 6);
    set_prio(4, 1); set_prio(5, 7); set_prio(6, 7); set_prio(7, 7);
    cfg_write(3'd0, 32'h7F);
    cfg_read(3'd0, rd); check(rd == 32'h7F, "R10 enable readback", rd, 32'h7F);

    // R2 / R9: disabled source stays pending, never offered, W1C clears
    pulse(8'h80); idle(3);
    check(irq_valid == 1'b0, "R2 disabled not offered", 32'(irq_valid), 0);
    cfg_read(3'd2, rd); check(rd == 32'h80, "R2 disabled stays pending", rd, 32'h80);
    cfg_write(3'd1, 32'h80);
    cfg_read(3'd2, rd); check(rd == 0, "R9 write-one clear", rd, 0);

    auto_take = 1'b1;

    // R4: basic take
    expect_take(0);
    pulse(8'h01); idle(2);
    check(exp_q.size() == 0, "R4 source 0 served", 32'(exp_q.size()), 0);
    cfg_read(3'd4, rd); check(rd == 1, "R5 depth after take", rd, 1);
    ret(); idle(2);

    // R3: tie on priority, lowest index first; other waits (R6)
    expect_take(1); expect_take(2);
    pulse(8'h06); idle(3);
    check(exp_q.size() == 1, "R3 tie lowest index first", 32'(exp_q.size()), 1);
    ret();
    check(irq_valid == 1'b1, "R6 offer right after return", 32'(irq_valid), 1);
    idle(2);
    check(exp_q.size() == 0, "R6 waiting source served", 32'(exp_q.size()), 0);
    ret(); idle(2);

    // R3: urgency beats index
    expect_take(4); expect_take(0);
    pulse(8'h11); idle(3);
    check(exp_q.size() == 1, "R3 higher urgency first", 32'(exp_q.size()), 1);
    ret(); idle(3);
    ret(); idle(2);

    // R5: strict preemption and nesting
    expect_take(0);
    pulse(8'h01); idle(2);
    expect_take(4);
    pulse(8'h10); idle(2);
    cfg_read(3'd4, rd); check(rd == 2, "R5 nested depth", rd, 2);
    ret();
    cfg_read(3'd4, rd); check(rd == 1, "R5 preempted resumes", rd, 1);
    ret();
    cfg_read(3'd4, rd); check(rd == 0, "R5 all returned", rd, 0);

    // R6: lower urgency waits
    expect_take(1);
    pulse(8'h02); idle(2);
    pulse(8'h01); idle(3);
    check(irq_valid == 1'b0, "R6 lower urgency not offered", 32'(irq_valid), 0);
    cfg_read(3'd2, rd); check(rd == 32'h01, "R6 lower urgency pending", rd, 32'h01);
    expect_take(0);
    ret(); idle(2);
    check(exp_q.size() == 0, "R6 served after return", 32'(exp_q.size()), 0);
    ret(); idle(2);

    // R7: repeated edges collapse
    expect_take(1);
    pulse(8'h02); idle(2);
    pulse(8'h08); pulse(8'h08); pulse(8'h08); idle(2);
    expect_take(3);
    ret(); idle(3);
    check(exp_q.size() == 0, "R7 one service", 32'(exp_q.size()), 0);
    ret(); idle(4);
    check(irq_valid == 1'b0, "R7 no second service", 32'(irq_valid), 0);
    cfg_read(3'd4, rd); check(rd == 0, "R7 depth back to zero", rd, 0);

    // R8: new edge in the take cycle keeps the source pending
    auto_take = 1'b0;
    pulse(8'h01); idle(2);
    check(irq_valid == 1'b1 && irq_vector == vec_of(0), "R8 offer before take",
          irq_vector, vec_of(0));
    expect_take(0);
    @(negedge clk);
    irq_in[0] = 1'b1; force_take = 1'b1;
    @(negedge clk);
    force_take = 1'b0; irq_in[0] = 1'b0;
    idle(2);
    check(irq_valid == 1'b0, "R8 equal level not offered", 32'(irq_valid), 0);
    cfg_read(3'd2, rd); check(rd == 32'h01, "R8 pending kept", rd, 32'h01);
    auto_take = 1'b1;
    expect_take(0);
    ret(); idle(2);
    check(exp_q.size() == 0, "R8 taken again", 32'(exp_q.size()), 0);
    ret(); idle(2);
    cfg_read(3'd2, rd); check(rd == 0, "R8 cleared by take", rd, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule